// File: doc/BRIEF.md
# Multi-Zone Sensor Timing Sequencer

This block steps a sensor measurement cycle through five timed zones, named P, A, B, C and D. The zones always run in that order. A low-frequency real-time clock drives the timing. The block samples that clock as a level on the system clock. Each rising edge of it is one timing tick, and each falling edge marks the middle of a tick. Every zone lasts a programmed number of ticks. In the periodic modes a wait zone follows zone D and fills out the rest of a programmed sample period.

Two special period codes change how sequences follow one another. One runs a single sequence and then waits for a new start request. The other runs sequences back to back: after the first pass, zone D leads straight into zone A, with no P zone and no wait.

A wake code picks one event to mark with a pulse: the start of one zone, or the end of the sequence. One wake code also stops the sequencer. Two bias outputs can each be enabled in zones P, A, B and C, and each has its own polarity. Each bias can also be offset, which trims half a tick from both ends of its pulse.

Top module: `zone_seq`

## Requirements
- R1: While reset is held and just after it, `state_o` is 0 (idle), `zone_start_o` and `wake_o` are 0, and each bias output sits at its idle level. The idle level is high when `bias_pol_i` is 0 and low when it is 1.
- R2: Each rising edge of `rtc_i` is one tick. State encodings are: 0 idle, 1 P, 2 A, 3 B, 4 C, 5 D, 6 wait. A tick in idle with `start_i` high enters P. Zones then follow the order P, A, B, C, D. Zone k takes its length from `zone_len_i[k]` (index 0 is P, up to index 4 for D) and lasts max(length, 1) ticks, unless R11 stretches it. The state changes only on ticks.
- R3: For `period_code_i` c from 0 to 10, each P entry follows the previous P entry by exactly 4<<c ticks, provided the zones fit in that time. Codes 11 to 13 act as code 10, giving 4096 ticks.
- R4: The wait zone lasts the period minus the total zone time. If zone D ends at or after the period boundary, the next P starts on that same tick with no wait.
- R5: Code 14 (single) returns to idle when zone D ends. No new sequence starts while `start_i` stays high. After `start_i` has been low for at least one clock, it must be raised again before the next sequence can start.
- R6: Code 15 (consecutive) goes straight from the end of zone D into zone A. It skips P and the wait.
- R7: For `wake_mode_i` w from 1 to 5, `wake_o` pulses for one clock on entry into the zone whose state code equals w.
- R8: For wake codes 6 and 7, `wake_o` pulses on the tick that ends zone D. Code 7 also returns to idle and locks the sequencer, as in R5.
- R9: If `start_i` falls during a sequence, that sequence still runs through zone D and then goes to idle, with no wait zone.
- R10: A bias whose offset is off is active for the whole of every zone enabled in `bias_zone_en_i`. Bits 0 to 3 of that field enable zones P, A, B and C.
- R11: A zone in which a bias is enabled lasts at least 2 ticks. If that bias has its offset on, the zone lasts at least 3 ticks.
- R12: A bias with its offset on goes active at the first falling edge of `rtc_i` in the zone. It goes inactive at the falling edge inside the zone's last tick.
- R13: `zone_start_o` pulses for one clock on every entry into zones P to D, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rtc_i | input | 1 | Low-frequency timing clock, sampled as a level |
| start_i | input | 1 | Run request |
| zone_len_i | input | 5x3 | Zone lengths in ticks (index 0 is P, index 4 is D) |
| period_code_i | input | 4 | Sample period code |
| wake_mode_i | input | 3 | Wake event select |
| bias_zone_en_i | input | NBIAS x 4 | Per-bias zone enables (bits 0 to 3 are P, A, B, C) |
| bias_pol_i | input | NBIAS | 1 = idle low and pulse high, 0 = idle high and pulse low |
| bias_ofs_i | input | NBIAS | Half-tick offset enable |
| state_o | output | 3 | Current sequencer state |
| zone_start_o | output | 1 | One-clock pulse on zone entry |
| wake_o | output | 1 | One-clock wake pulse |
| bias_o | output | NBIAS | Bias outputs |

## Verification
The period logic is tried with several zone-length sets: all zero, all one, mixed, and all at maximum. These are paired with period codes that leave a short wait, a long wait, no wait, or an overrun, plus one reserved code. Measuring the spacing between P entries separates the ordinary wait from an overrun and from a wrong shift. Counting the ticks spent in each state catches a zone that is dropped, taken out of order, or given the wrong length. Short directed runs cover:
- what follows zone D in each mode, and in each case of start being released;
- each kind of wake;
- the bias outputs, sampled at both the rising and falling RTC edges, with and without offset.

Sampling at both edges separates a full-zone pulse from an offset pulse.

// File: rtl/zone_seq_pkg.sv
package zone_seq_pkg;
    localparam int NZONE      = 5;
    localparam int NBZONE     = 4;
    localparam int LEN_W      = 3;
    localparam int PCODE_W    = 4;
    localparam int WAKE_W     = 3;
    localparam int MAX_SHIFT  = 10;
    localparam int BASE_TICKS = 4;
    localparam int PER_W      = $clog2(BASE_TICKS << MAX_SHIFT) + 2;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_P    = 3'd1,
        ST_A    = 3'd2,
        ST_B    = 3'd3,
        ST_C    = 3'd4,
        ST_D    = 3'd5,
        ST_WAIT = 3'd6
    } seq_state_e;

    localparam logic [PCODE_W-1:0] PC_SINGLE = 4'd14;
    localparam logic [PCODE_W-1:0] PC_CONSEC = 4'd15;
    localparam logic [WAKE_W-1:0]  WK_END    = 3'd6;
    localparam logic [WAKE_W-1:0]  WK_STOP   = 3'd7;

    function automatic logic [PER_W-1:0] period_ticks(input logic [PCODE_W-1:0] code);
        logic [PER_W-1:0] base;
        base = PER_W'(BASE_TICKS);
        if (code > PCODE_W'(MAX_SHIFT)) return base << MAX_SHIFT;
        return base << code;
    endfunction

    // Zone length after applying the one-tick floor and any bias minimum.
    function automatic logic [LEN_W-1:0] zone_ticks(input logic [LEN_W-1:0] len,
                                                    input logic [1:0] need);
        logic [LEN_W-1:0] floor_v;
        floor_v = {{(LEN_W-2){1'b0}}, need};
        if (floor_v == '0) floor_v = LEN_W'(1);
        return (len > floor_v) ? len : floor_v;
    endfunction

    function automatic logic zone_hit(input seq_state_e s, input logic [NBZONE-1:0] en);
        case (s)
            ST_P:    return en[0];
            ST_A:    return en[1];
            ST_B:    return en[2];
            ST_C:    return en[3];
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/zone_seq_edge.sv
module zone_seq_edge (
    input  logic clk,
    input  logic rst,
    input  logic rtc_i,
    output logic rise_o,
    output logic fall_o
);
    logic rtc_q;

    always_ff @(posedge clk) begin
        if (rst) rtc_q <= 1'b0;
        else     rtc_q <= rtc_i;
    end

    assign rise_o = rtc_i & ~rtc_q;
    assign fall_o = ~rtc_i & rtc_q;
endmodule

// File: rtl/zone_seq_fsm.sv
module zone_seq_fsm
    import zone_seq_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             tick,
    input  logic                             start,
    input  logic [NZONE-1:0][LEN_W-1:0]      zone_len,
    input  logic [NZONE-1:0][1:0]            need,
    input  logic [PCODE_W-1:0]               period_code,
    input  logic [WAKE_W-1:0]                wake_mode,
    output seq_state_e                       state_o,
    output logic [LEN_W-1:0]                 zcnt_o,
    output logic                             zone_start_o,
    output logic                             wake_o
);
    seq_state_e       state, nxt, tgt;
    logic [LEN_W-1:0] zcnt, nzcnt;
    logic [PER_W-1:0] per, nper, per_inc, period;
    logic             lock, nlock, do_enter, end_seq;
    logic [2:0]       zi;

    always_comb begin
        nxt      = state;
        nzcnt    = zcnt;
        nper     = per;
        nlock    = lock & start;
        tgt      = ST_IDLE;
        do_enter = 1'b0;
        end_seq  = 1'b0;
        zi       = '0;
        per_inc  = per + PER_W'(1);
        period   = period_ticks(period_code);
        if (tick) begin
            if (state != ST_IDLE) nper = per_inc;
            case (state)
                ST_IDLE: if (start && !lock) begin tgt = ST_P; do_enter = 1'b1; end
                ST_P, ST_A, ST_B, ST_C: begin
                    if (zcnt == LEN_W'(1)) begin
                        tgt      = seq_state_e'(state + 3'd1);
                        do_enter = 1'b1;
                    end else nzcnt = zcnt - LEN_W'(1);
                end
                ST_D: begin
                    if (zcnt == LEN_W'(1)) begin
                        end_seq = 1'b1;
                        if (wake_mode == WK_STOP || period_code == PC_SINGLE) begin
                            nxt   = ST_IDLE;
                            nlock = 1'b1;
                        end else if (!start)                 nxt = ST_IDLE;
                        else if (period_code == PC_CONSEC) begin tgt = ST_A; do_enter = 1'b1; end
                        else if (per_inc >= period)      begin tgt = ST_P; do_enter = 1'b1; end
                        else                                 nxt = ST_WAIT;
                    end else nzcnt = zcnt - LEN_W'(1);
                end
                ST_WAIT: begin
                    if (per_inc >= period) begin
                        if (start) begin tgt = ST_P; do_enter = 1'b1; end
                        else nxt = ST_IDLE;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
            if (do_enter) begin
                nxt   = tgt;
                zi    = 3'(tgt) - 3'd1;
                nzcnt = zone_ticks(zone_len[zi], need[zi]);
                if (tgt == ST_P) nper = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            zcnt         <= '0;
            per          <= '0;
            lock         <= 1'b0;
            zone_start_o <= 1'b0;
            wake_o       <= 1'b0;
        end else begin
            state        <= nxt;
            zcnt         <= nzcnt;
            per          <= nper;
            lock         <= nlock;
            zone_start_o <= do_enter;
            wake_o       <= (do_enter && wake_mode == 3'(tgt)) ||
                            (end_seq && wake_mode >= WK_END);
        end
    end

    assign state_o = state;
    assign zcnt_o  = zcnt;
endmodule

// File: rtl/zone_seq_bias.sv
module zone_seq_bias
    import zone_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              half,
    input  seq_state_e        state,
    input  logic [LEN_W-1:0]  zcnt,
    input  logic [NBZONE-1:0] zone_en,
    input  logic              pol,
    input  logic              ofs,
    output logic              bias_o
);
    logic act_q, act;

    // Offset pulse: updated only on mid-tick edges, dropped in the zone's last tick.
    always_ff @(posedge clk) begin
        if (rst)       act_q <= 1'b0;
        else if (half) act_q <= zone_hit(state, zone_en) && (zcnt != LEN_W'(1));
    end

    assign act    = ofs ? act_q : zone_hit(state, zone_en);
    assign bias_o = pol ? act : ~act;
endmodule

// File: rtl/zone_seq.sv
module zone_seq
    import zone_seq_pkg::*;
#(
    parameter int NBIAS = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          rtc_i,
    input  logic                          start_i,
    input  logic [NZONE-1:0][LEN_W-1:0]   zone_len_i,
    input  logic [PCODE_W-1:0]            period_code_i,
    input  logic [WAKE_W-1:0]             wake_mode_i,
    input  logic [NBIAS-1:0][NBZONE-1:0]  bias_zone_en_i,
    input  logic [NBIAS-1:0]              bias_pol_i,
    input  logic [NBIAS-1:0]              bias_ofs_i,
    output logic [2:0]                    state_o,
    output logic                          zone_start_o,
    output logic                          wake_o,
    output logic [NBIAS-1:0]              bias_o
);
    logic                  rtc_rise, rtc_fall;
    logic [NZONE-1:0][1:0] need;
    seq_state_e            state_w;
    logic [LEN_W-1:0]      zcnt_w;

    zone_seq_edge u_edge (
        .clk(clk), .rst(rst), .rtc_i(rtc_i), .rise_o(rtc_rise), .fall_o(rtc_fall)
    );

    // Minimum zone length demanded by the biases enabled in each zone.
    always_comb begin
        need = '0;
        for (int z = 0; z < NBZONE; z++) begin
            for (int b = 0; b < NBIAS; b++) begin
                if (bias_zone_en_i[b][z]) begin
                    if (bias_ofs_i[b])          need[z] = 2'd3;
                    else if (need[z] < 2'd2)    need[z] = 2'd2;
                end
            end
        end
    end

    zone_seq_fsm u_fsm (
        .clk(clk), .rst(rst), .tick(rtc_rise), .start(start_i),
        .zone_len(zone_len_i), .need(need), .period_code(period_code_i),
        .wake_mode(wake_mode_i), .state_o(state_w), .zcnt_o(zcnt_w),
        .zone_start_o(zone_start_o), .wake_o(wake_o)
    );

    for (genvar b = 0; b < NBIAS; b++) begin : g_bias
        zone_seq_bias u_bias (
            .clk(clk), .rst(rst), .half(rtc_fall), .state(state_w), .zcnt(zcnt_w),
            .zone_en(bias_zone_en_i[b]), .pol(bias_pol_i[b]), .ofs(bias_ofs_i[b]),
            .bias_o(bias_o[b])
        );
    end

    assign state_o = state_w;
endmodule

// File: rtl/zone_seq_chk.sv
module zone_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic [2:0] state,
    input logic       zone_start,
    input logic       wake,
    input logic [3:0] period_code
);
    p_state_legal_r2: assert property (@(posedge clk) disable iff (rst)
        state != 3'd7);

    p_tick_only_r2: assert property (@(posedge clk) disable iff (rst)
        (state != $past(state)) |-> $past(tick));

    p_zone_order_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(state) >= 3'd1 && $past(state) <= 3'd4 && state != $past(state))
        |-> (state == $past(state) + 3'd1));

    p_single_idle_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(period_code) == 4'd14 && $past(state) == 3'd5 && state != 3'd5)
        |-> (state == 3'd0));

    p_consec_to_a_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(period_code) == 4'd15 && $past(state) == 3'd5 && state != 3'd5)
        |-> (state == 3'd2 || state == 3'd0));

    p_wake_on_change_r7: assert property (@(posedge clk) disable iff (rst)
        wake |-> (state != $past(state)));

    p_entry_pulse_r13: assert property (@(posedge clk) disable iff (rst)
        zone_start |-> (state >= 3'd1 && state <= 3'd5 && state != $past(state)));

    p_entry_single_r13: assert property (@(posedge clk) disable iff (rst)
        zone_start |=> !zone_start);
endmodule

bind zone_seq zone_seq_chk chk_i (
    .clk(clk), .rst(rst), .tick(rtc_rise), .state(state_o),
    .zone_start(zone_start_o), .wake(wake_o), .period_code(period_code_i)
);

// File: tb/zone_seq_tb_top.sv
module zone_seq_tb_top;
    import zone_seq_pkg::*;
    localparam int NB = 2;

    typedef struct packed {
        logic [2:0]  lp, la, lb, lc, ld;
        logic [3:0]  code;
        logic [12:0] ival;
        logic [12:0] waitn;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{3'd1, 3'd1, 3'd1, 3'd1, 3'd1, 4'd0,  13'd5,    13'd0},
        '{3'd1, 3'd2, 3'd1, 3'd1, 3'd1, 4'd1,  13'd8,    13'd2},
        '{3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 4'd0,  13'd5,    13'd0},
        '{3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 4'd5,  13'd128,  13'd93},
        '{3'd3, 3'd1, 3'd4, 3'd1, 3'd5, 4'd2,  13'd16,   13'd2},
        '{3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 4'd3,  13'd32,   13'd12},
        '{3'd2, 3'd2, 3'd2, 3'd2, 3'd2, 4'd11, 13'd4096, 13'd4086},
        '{3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 4'd0,  13'd35,   13'd0}
    };

    logic clk = 1'b0, rst = 1'b1, rtc = 1'b0, start = 1'b0;
    logic [NZONE-1:0][LEN_W-1:0] zlen = '0;
    logic [3:0] pcode = '0;
    logic [2:0] wmode = '0;
    logic [NB-1:0][3:0] ben = '0;
    logic [NB-1:0] bpol = '0, bofs = '0;
    logic [2:0] st;
    logic zs, wk;
    logic [NB-1:0] bias;
    int errors = 0, checks = 0;
    bit done = 1'b0;

    logic [2:0] s_st;
    logic s_zs, s_wk, s_late;
    logic [NB-1:0] s_brise, s_bhalf;
    int cnt [8];

    always #10 clk = ~clk;

    zone_seq #(.NBIAS(NB)) dut_i (
        .clk(clk), .rst(rst), .rtc_i(rtc), .start_i(start), .zone_len_i(zlen),
        .period_code_i(pcode), .wake_mode_i(wmode), .bias_zone_en_i(ben),
        .bias_pol_i(bpol), .bias_ofs_i(bofs), .state_o(st), .zone_start_o(zs),
        .wake_o(wk), .bias_o(bias)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One RTC period of four clocks, sampling after the rising and falling edges.
    task automatic rtc_cycle();
        @(negedge clk) rtc = 1'b1;
        @(negedge clk) begin s_st = st; s_zs = zs; s_wk = wk; s_brise = bias; end
        @(negedge clk) rtc = 1'b0;
        @(negedge clk) begin s_bhalf = bias; s_late = zs | wk; end
    endtask

    task automatic do_reset();
        @(negedge clk) begin rst = 1'b1; start = 1'b0; rtc = 1'b0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic set_all_len(input logic [2:0] l);
        for (int z = 0; z < NZONE; z++) zlen[z] = l;
    endtask

    task automatic expect_state(input string req, input int exp);
        rtc_cycle();
        chk(req, s_st, exp);
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int entries, t0, tk, ival, zsc, prev, lens [5];

        // R1: reset state and idle bias levels
        bpol = 2'b10;
        do_reset();
        chk("R1 state", st, 0);
        chk("R1 zone_start", zs, 0);
        chk("R1 wake", wk, 0);
        chk("R1 bias idle", bias, 2'b01);

        // Table: period spacing (R3), wait length (R4), zone order/length (R2), entries (R13)
        for (int v = 0; v < 8; v++) begin
            bpol = '0;
            do_reset();
            zlen[0] = VEC[v].lp; zlen[1] = VEC[v].la; zlen[2] = VEC[v].lb;
            zlen[3] = VEC[v].lc; zlen[4] = VEC[v].ld;
            lens = '{VEC[v].lp, VEC[v].la, VEC[v].lb, VEC[v].lc, VEC[v].ld};
            pcode = VEC[v].code; wmode = 3'd0; ben = '0; bofs = '0;
            start = 1'b1;
            for (int i = 0; i < 8; i++) cnt[i] = 0;
            entries = 0; t0 = 0; tk = 0; ival = 0; zsc = 0; prev = 0;
            while (entries < 2 && tk < 6000) begin
                rtc_cycle();
                tk++;
                if (s_st == 3'd1 && prev != 1) begin
                    entries++;
                    if (entries == 1) t0 = tk; else ival = tk - t0;
                end
                if (entries == 1) begin
                    cnt[s_st]++;
                    if (s_zs) zsc++;
                end
                prev = s_st;
            end
            chk("R3 period spacing", ival, VEC[v].ival);
            chk("R4 wait ticks", cnt[6], VEC[v].waitn);
            for (int z = 0; z < NZONE; z++)
                chk("R2 zone ticks", cnt[z+1], (lens[z] == 0) ? 1 : lens[z]);
            chk("R13 entry pulses", zsc, 5);
        end

        // R5 single mode with R7 wake at zone B entry
        do_reset();
        set_all_len(3'd1); pcode = 4'd14; wmode = 3'd3; start = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            rtc_cycle();
            chk("R5 single seq", s_st, (k <= 5) ? k : 0);
            chk("R7 wake zone B", s_wk, (k == 3) ? 1 : 0);
            chk("R13 pulse one clock", s_late, 0);
        end
        start = 1'b0;
        expect_state("R5 idle with start low", 0);
        start = 1'b1;
        expect_state("R5 restart", 1);

        // R6 consecutive
        do_reset();
        set_all_len(3'd1); pcode = 4'd15; wmode = 3'd0; start = 1'b1;
        for (int k = 1; k <= 10; k++)
            expect_state("R6 consecutive", (k <= 5) ? k : ((k - 6) % 4) + 2);

        // R9 start released mid-sequence
        do_reset();
        set_all_len(3'd1); pcode = 4'd5; start = 1'b1;
        expect_state("R9 P", 1);
        expect_state("R9 A", 2);
        start = 1'b0;
        for (int k = 3; k <= 7; k++) expect_state("R9 finish then idle", (k <= 5) ? k : 0);

        // R8 wake at sequence end, code 6
        do_reset();
        set_all_len(3'd1); pcode = 4'd3; wmode = 3'd6; start = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            rtc_cycle();
            chk("R8 end wake", s_wk, (k == 6) ? 1 : 0);
        end
        chk("R8 wait after end", s_st, 6);

        // R8 wake and stop, code 7
        do_reset();
        set_all_len(3'd1); pcode = 4'd3; wmode = 3'd7; start = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            rtc_cycle();
            chk("R8 stop wake", s_wk, (k == 6) ? 1 : 0);
            if (k >= 6) chk("R8 stop idle", s_st, 0);
        end

        // R10 full-zone bias with both polarities
        bpol = 2'b01; bofs = 2'b00; ben[0] = 4'b0010; ben[1] = 4'b1001;
        do_reset();
        set_all_len(3'd2); pcode = 4'd14; wmode = 3'd0; start = 1'b1;
        for (int k = 1; k <= 11; k++) begin
            int zn, b0, b1;
            zn = (k <= 10) ? ((k - 1) / 2) + 1 : 0;
            b0 = (zn == 2) ? 1 : 0;
            b1 = (zn == 1 || zn == 4) ? 0 : 1;
            rtc_cycle();
            chk("R10 bias rise", s_brise, (b1 << 1) | b0);
            chk("R10 bias half", s_bhalf, (b1 << 1) | b0);
        end

        // R11 minimum zone length and R12 offset pulse
        bpol = 2'b11; bofs = 2'b10; ben[0] = 4'b0100; ben[1] = 4'b1000;
        do_reset();
        set_all_len(3'd0); pcode = 4'd14; start = 1'b1;
        for (int k = 1; k <= 9; k++) begin
            int es, r0, r1, h1;
            es = (k <= 2) ? k : (k <= 4) ? 3 : (k <= 7) ? 4 : (k == 8) ? 5 : 0;
            r0 = (k == 3 || k == 4) ? 1 : 0;
            r1 = (k == 6 || k == 7) ? 1 : 0;
            h1 = (k == 5 || k == 6) ? 1 : 0;
            rtc_cycle();
            chk("R11 stretched zones", s_st, es);
            chk("R11 bias no offset", s_brise[0], r0);
            chk("R12 offset at rise", s_brise[1], r1);
            chk("R12 offset at half", s_bhalf[1], h1);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule